// File: doc/BRIEF.md
# SD Command and Response Engine

This block issues one command to an SD or MMC card over the single-wire CMD line and collects the card's answer. On a start pulse it takes a 6-bit command index, a 32-bit argument and a 3-bit response-format code. It builds a 48-bit frame with a CRC7 that it generates itself, and shifts the frame out most significant bit first, one bit per clock. If an initialization flag comes with the start pulse, the block first holds the line high for a run of clocks so that a freshly powered card can wake up.

When the format code asks for a response, the block releases the line. It then waits a programmable number of clocks for the card's start bit and captures either a 48-bit or a 136-bit reply. On the short format with a checked CRC it verifies the CRC7. It raises a completion status, a sticky interrupt flag and, when needed, a timeout or CRC-error status. Software reads the reply back through a halfword port that advances one 16-bit entry per pop. The byte alignment of that port is fixed, so that software can regroup the halfwords into 32-bit words.

In the clock domain of the block, one clock stands for one card clock. Data transfer and busy signalling on the data lines are handled elsewhere.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted start puts on `cmd_out` the frame 0, 1, index[5:0], argument[31:0], CRC7[6:0], 1, most significant bit first and one bit per clock. The first bit appears in the cycle after the start edge. The CRC7 uses polynomial x^7+x^3+1 (feedback mask 7'h09), starts from zero, and covers the first 40 frame bits. `cmd_oe` is high for every frame bit.
- R2: With `init_seq` set at start, `cmd_out` and `cmd_oe` stay high for PRE_LEN (default 80) cycles before the frame's first bit.
- R3: Format codes: 0 = no response, 1 = 48-bit response with CRC check, 2 = 136-bit response, 3 = 48-bit response without CRC check. Codes 4 to 7 behave as 0.
- R4: With no response, `rsp_done` and `rsp_irq` rise and `busy` falls at the edge that ends the frame's last bit.
- R5: After the frame, `cmd_oe` is low. The start bit (a 0 on `cmd_in`) is accepted in any of the first `rsp_wait` clocks (rsp_wait >= 1). If none arrives, `rsp_timeout`, `rsp_done` and `rsp_irq` are set and `busy` falls at the end of the last of those clocks.
- R6: The response is shifted in one bit per clock, starting with the start bit. `rsp_done` and `rsp_irq` rise and `busy` falls at the edge that samples the last bit.
- R7: For format 1, `rsp_crc_err` is set when the CRC7 over response bits 47:8 differs from bits 7:1. Formats 2 and 3 never set it.
- R8: `hw_data` shows the head halfword and `hw_pop` advances it. A 48-bit response R reads as R[47:32], R[31:16], {8'h00, R[15:8]}. A 136-bit response R reads as nine halfwords, taken from the top of {R, 8'h00}. Reads past the end, and all reads after an accepted start, return 0.
- R9: `rsp_irq` stays set until `irq_ack`. A completion in the same cycle as `irq_ack` leaves it set. `irq_ack` does not change `rsp_done`.
- R10: A start pulse while `busy` is high is ignored, and so are changes to the command inputs.
- R11: After reset: `busy`, `cmd_oe`, all flags and `hw_data` are 0 and `cmd_out` is 1.
- R12: An accepted start clears `rsp_done`, `rsp_timeout` and `rsp_crc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card clock per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| opcode | input | 6 | Command index |
| argument | input | 32 | Command argument |
| rsp_fmt | input | 3 | Response format code |
| init_seq | input | 1 | Send the wake-up preamble before the frame |
| rsp_wait | input | TO_W | Clocks to wait for the response start bit |
| cmd_in | input | 1 | CMD line as seen from the card |
| hw_pop | input | 1 | Advance the response halfword port |
| irq_ack | input | 1 | Clear the interrupt flag |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Command in progress |
| rsp_done | output | 1 | End of command/response status |
| rsp_irq | output | 1 | Sticky end-of-command interrupt flag |
| rsp_timeout | output | 1 | No response start bit arrived |
| rsp_crc_err | output | 1 | Response CRC mismatch |
| hw_data | output | 16 | Head halfword of the captured response |

## Verification
Two functions can meet in one cycle: completion, which sets `rsp_irq`, and software's `irq_ack`, which clears it. The bench raises `irq_ack` exactly for the edge that ends a frame with no response. After that edge it requires the flag to be set. A later lone acknowledge must clear the flag and leave `rsp_done` as it was. The bench also pulses `start` with a changed opcode in the middle of a frame, and requires the frame on the line to be the original one.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int TO_W    = 16,
  parameter int PRE_LEN = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [5:0]      opcode,
  input  logic [31:0]     argument,
  input  logic [2:0]      rsp_fmt,
  input  logic            init_seq,
  input  logic [TO_W-1:0] rsp_wait,
  input  logic            cmd_in,
  input  logic            hw_pop,
  input  logic            irq_ack,
  output logic            cmd_out,
  output logic            cmd_oe,
  output logic            busy,
  output logic            rsp_done,
  output logic            rsp_irq,
  output logic            rsp_timeout,
  output logic            rsp_crc_err,
  output logic [15:0]     hw_data
);
  localparam int FRAME_LEN = 48;
  localparam int BODY_LEN  = 40;
  localparam int LONG_LEN  = 136;
  localparam int BUF_W     = 144;
  localparam int CNT_MAX   = (PRE_LEN > LONG_LEN) ? PRE_LEN : LONG_LEN;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] BODY_END  = CNT_W'(BODY_LEN);
  localparam logic [CNT_W-1:0] CRC_END   = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_LST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LST  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] PRE_LST   = CNT_W'(PRE_LEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_TX, S_WAIT, S_RX} state_t;

  state_t               state;
  logic [CNT_W-1:0]     cnt;
  logic [TO_W-1:0]      wcnt, to_lim;
  logic [BODY_LEN-1:0]  tx_sr;
  logic [6:0]           crc;
  logic                 has_rsp, long_rsp, chk_crc;
  logic [LONG_LEN-2:0]  rx_sr;
  logic [BUF_W-1:0]     rbuf;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  logic tx_bit, accept, rx_last, wait_out;
  assign tx_bit   = (cnt < BODY_END) ? tx_sr[BODY_LEN-1] : (cnt < CRC_END) ? crc[6] : 1'b1;
  assign accept   = (state == S_IDLE) && start;
  assign rx_last  = cnt == (long_rsp ? LONG_LST : SHORT_LST);
  assign wait_out = ({1'b0, wcnt} + 1'b1) >= {1'b0, to_lim};

  assign busy    = state != S_IDLE;
  assign cmd_oe  = (state == S_PRE) || (state == S_TX);
  assign cmd_out = (state == S_TX) ? tx_bit : 1'b1;
  assign hw_data = rbuf[BUF_W-1 -: 16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      wcnt        <= '0;
      to_lim      <= '0;
      tx_sr       <= '0;
      crc         <= '0;
      has_rsp     <= 1'b0;
      long_rsp    <= 1'b0;
      chk_crc     <= 1'b0;
      rx_sr       <= '0;
      rbuf        <= '0;
      rsp_done    <= 1'b0;
      rsp_irq     <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_crc_err <= 1'b0;
    end else begin
      if (irq_ack) rsp_irq <= 1'b0;
      if (hw_pop)  rbuf <= {rbuf[BUF_W-17:0], 16'h0000};
      unique case (state)
        S_IDLE: if (start) begin
          state       <= init_seq ? S_PRE : S_TX;
          cnt         <= '0;
          tx_sr       <= {2'b01, opcode, argument};
          crc         <= '0;
          to_lim      <= rsp_wait;
          has_rsp     <= (rsp_fmt == 3'd1) || (rsp_fmt == 3'd2) || (rsp_fmt == 3'd3);
          long_rsp    <= rsp_fmt == 3'd2;
          chk_crc     <= rsp_fmt == 3'd1;
          rbuf        <= '0;
          rsp_done    <= 1'b0;
          rsp_timeout <= 1'b0;
          rsp_crc_err <= 1'b0;
        end
        S_PRE: begin
          if (cnt == PRE_LST) begin
            state <= S_TX;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_TX: begin
          if (cnt < BODY_END) begin
            tx_sr <= {tx_sr[BODY_LEN-2:0], 1'b0};
            crc   <= crc_step(crc, tx_sr[BODY_LEN-1]);
          end else crc <= {crc[5:0], 1'b0};
          if (cnt == SHORT_LST) begin
            cnt  <= '0;
            wcnt <= '0;
            if (has_rsp) state <= S_WAIT;
            else begin
              state    <= S_IDLE;
              rsp_done <= 1'b1;
              rsp_irq  <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: begin
          if (!cmd_in) begin
            state <= S_RX;
            cnt   <= CNT_W'(1);
            crc   <= '0;
            rx_sr <= {rx_sr[LONG_LEN-3:0], cmd_in};
          end else if (wait_out) begin
            state       <= S_IDLE;
            rsp_timeout <= 1'b1;
            rsp_done    <= 1'b1;
            rsp_irq     <= 1'b1;
          end else wcnt <= wcnt + 1'b1;
        end
        S_RX: begin
          rx_sr <= {rx_sr[LONG_LEN-3:0], cmd_in};
          if (cnt < BODY_END) crc <= crc_step(crc, cmd_in);
          cnt <= cnt + 1'b1;
          if (rx_last) begin
            state       <= S_IDLE;
            rsp_done    <= 1'b1;
            rsp_irq     <= 1'b1;
            rsp_crc_err <= chk_crc && (crc != rx_sr[6:0]);
            if (long_rsp) rbuf <= {rx_sr, cmd_in, 8'h00};
            else          rbuf <= {rx_sr[46:15], 8'h00, rx_sr[14:7], 96'h0};
          end
        end
        default: state <= S_IDLE;
      endcase
      if (accept) rsp_irq <= rsp_irq && !irq_ack;
    end
  end
endmodule

module sd_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic irq_ack,
  input logic cmd_out,
  input logic cmd_oe,
  input logic busy,
  input logic rsp_done,
  input logic rsp_irq,
  input logic rsp_timeout,
  input logic rsp_crc_err
);
  // R1
  oe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_oe |-> busy);
  // R11
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !cmd_oe |-> cmd_out);
  // R10
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R4
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rsp_done) |-> !busy);
  // R5
  timeout_is_done_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_timeout |-> (rsp_done && !rsp_crc_err));
  // R7
  crc_err_is_done_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_crc_err |-> rsp_done);
  // R9
  irq_clear_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(rsp_irq) |-> $past(irq_ack));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .irq_ack(irq_ack),
  .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .rsp_done(rsp_done),
  .rsp_irq(rsp_irq), .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err)
);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  localparam int TO_W = 16;
  localparam int PRE_LEN = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, init_seq = 1'b0, cmd_in = 1'b1, hw_pop = 1'b0, irq_ack = 1'b0;
  logic [5:0] opcode = '0;
  logic [31:0] argument = '0;
  logic [2:0] rsp_fmt = '0;
  logic [TO_W-1:0] rsp_wait = '0;
  logic cmd_out, cmd_oe, busy, rsp_done, rsp_irq, rsp_timeout, rsp_crc_err;
  logic [15:0] hw_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sd_cmd_engine #(.TO_W(TO_W), .PRE_LEN(PRE_LEN)) i_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .argument(argument),
    .rsp_fmt(rsp_fmt), .init_seq(init_seq), .rsp_wait(rsp_wait), .cmd_in(cmd_in),
    .hw_pop(hw_pop), .irq_ack(irq_ack), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .busy(busy), .rsp_done(rsp_done), .rsp_irq(rsp_irq), .rsp_timeout(rsp_timeout),
    .rsp_crc_err(rsp_crc_err), .hw_data(hw_data));

  task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [15:0] hw_exp(input logic [135:0] r, input bit lng, input int k);
    logic [143:0] s;
    if (lng) s = {r, 8'h00};
    else s = {r[47:16], 8'h00, r[15:8], 96'h0};
    return s[143 - 16*k -: 16];
  endfunction

  task automatic run_cmd(input logic [5:0] op, input logic [31:0] arg, input logic [2:0] fmt,
                         input bit init, input int wait_n, input int delay, input bit corrupt,
                         input bit ack_at_end, input bit poke);
    logic [47:0] exp_frame, got;
    logic [135:0] r;
    bit ok, has, lng;
    int len;
    exp_frame = {2'b01, op, arg, crc7({2'b01, op, arg}), 1'b1};
    @(negedge clk);
    opcode = op; argument = arg; rsp_fmt = fmt; init_seq = init;
    rsp_wait = TO_W'(wait_n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (init) begin
      ok = 1;
      repeat (PRE_LEN) begin
        if (!(cmd_oe && cmd_out)) ok = 0;
        @(negedge clk);
      end
      chk(ok, "R2 preamble", {cmd_oe, cmd_out}, 2'b11);
    end
    ok = 1;
    for (int k = 0; k < 48; k++) begin
      got[47-k] = cmd_out;
      if (!cmd_oe) ok = 0;
      if (poke && k == 20) begin start = 1'b1; opcode = ~op; end
      if (ack_at_end && k == 47) irq_ack = 1'b1;
      @(negedge clk);
      start = 1'b0; irq_ack = 1'b0;
    end
    chk(got == exp_frame && ok, poke ? "R10 frame unchanged by start while busy" : "R1 frame",
        got, exp_frame);
    has = (fmt == 3'd1) || (fmt == 3'd2) || (fmt == 3'd3);
    lng = fmt == 3'd2;
    if (!has) begin
      chk(rsp_done && rsp_irq && !busy && !cmd_oe, "R4 R3 done without response",
          {busy, rsp_done, rsp_irq}, 3'b011);
      return;
    end
    len = lng ? 136 : 48;
    r = '0;
    for (int i = 0; i < 5; i++) r[32*i +: 32] = $urandom;
    if (lng) r[135] = 1'b0;
    else begin
      r[135:48] = '0;
      r[47:46] = 2'b00;
      r[7:1] = crc7(r[47:8]);
      r[0] = 1'b1;
      if (corrupt) r[1] = ~r[1];
    end
    ok = 1;
    if (delay >= wait_n) begin
      repeat (wait_n) begin
        cmd_in = 1'b1;
        if (cmd_oe) ok = 0;
        @(negedge clk);
      end
      chk(rsp_timeout && rsp_done && rsp_irq && !busy && ok, "R5 timeout",
          {busy, rsp_done, rsp_timeout}, 3'b011);
      chk(hw_data == 16'h0, "R8 cleared after start", hw_data, 16'h0);
      return;
    end
    repeat (delay) begin
      cmd_in = 1'b1;
      if (cmd_oe) ok = 0;
      @(negedge clk);
    end
    for (int i = 0; i < len; i++) begin
      cmd_in = r[len-1-i];
      if (cmd_oe) ok = 0;
      if (i == len - 1 && rsp_done) ok = 0;
      @(negedge clk);
    end
    cmd_in = 1'b1;
    chk(ok && rsp_done && rsp_irq && !busy && !rsp_timeout, "R6 R5 response captured",
        {busy, rsp_done, rsp_timeout}, 3'b010);
    chk(rsp_crc_err == (fmt == 3'd1 && corrupt), "R7 crc flag", rsp_crc_err, (fmt == 3'd1 && corrupt));
    hw_pop = 1'b1;
    for (int k = 0; k < (lng ? 9 : 3); k++) begin
      chk(hw_data == hw_exp(r, lng, k), lng ? "R8 long halfword" : "R8 short halfword",
          hw_data, hw_exp(r, lng, k));
      @(negedge clk);
    end
    hw_pop = 1'b0;
    chk(hw_data == 16'h0, "R8 past end", hw_data, 16'h0);
  endtask

  task automatic ack_irq();
    bit d;
    @(negedge clk);
    d = rsp_done;
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(!rsp_irq && rsp_done == d, "R9 ack clears irq only", {rsp_irq, rsp_done}, {1'b0, d});
  endtask

  initial begin
    int to;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_oe && cmd_out && !rsp_done && !rsp_irq && !rsp_timeout && !rsp_crc_err
        && hw_data == 0, "R11 reset state",
        {busy, cmd_oe, cmd_out, rsp_done, rsp_irq, hw_data}, {5'b00100, 16'h0});
    rst_n = 1'b1;
    run_cmd(6'd0, 32'h0, 3'd0, 1'b1, 8, 0, 0, 1, 0);
    chk(rsp_irq, "R9 set wins over ack in same cycle", rsp_irq, 1'b1);
    ack_irq();
    run_cmd(6'd17, 32'hDEAD_BEEF, 3'd1, 0, 10, 2, 0, 0, 0);
    chk(rsp_done, "R12 precondition done set", rsp_done, 1'b1);
    run_cmd(6'd17, 32'h0000_0200, 3'd1, 0, 10, 0, 1, 0, 0);
    run_cmd(6'd41, 32'h40FF_8000, 3'd3, 0, 10, 1, 1, 0, 0);
    run_cmd(6'd2, 32'h0, 3'd2, 0, 12, 3, 0, 0, 0);
    run_cmd(6'd9, 32'h1234_0000, 3'd1, 0, 5, 5, 0, 0, 0);
    run_cmd(6'd9, 32'h1234_0000, 3'd1, 0, 5, 4, 0, 0, 0);
    chk(!rsp_timeout, "R12 start cleared timeout", rsp_timeout, 1'b0);
    run_cmd(6'd55, 32'hA5A5_5A5A, 3'd0, 0, 5, 0, 0, 0, 1);
    chk(!busy, "R10 no second command", busy, 1'b0);
    run_cmd(6'd7, 32'h0F0F_0F0F, 3'd5, 0, 5, 0, 0, 0, 0);
    ack_irq();
    for (int n = 0; n < 16; n++) begin
      logic [2:0] f = 3'($urandom_range(0, 3));
      to = $urandom_range(1, 20);
      run_cmd(6'($urandom), $urandom, f, 1'($urandom), to, $urandom_range(0, to),
              1'($urandom), 0, 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule